// File: doc/BRIEF.md
# Bit-Field Execution Unit

This unit computes one 32-bit result per start strobe from the current value of a destination register and a set of operands. It can zero a field of any position and width, merge the low bits of a source operand into such a field, mirror the whole source word end to end, load a 16-bit constant into either half of the word, or shift the source left by a given amount. Every operation except the reversal and the shift uses the old destination value, so the unit sits beside a register file read port that supplies that value.

The operation, the operands, the field start position and the field width are sampled on the clock edge at which start is high. The result, a valid flag and an illegal flag are registered on that edge. A field that runs past bit 31, a zero width, or an unused operation code raises the illegal flag, and the destination value passes through unchanged.

Top module: `bfu_top`

## Requirements
- R1: With op = 0 (field clear), bits lsb through lsb+width-1 of the result are zero and every other bit equals dest.
- R2: With op = 1 (field insert), bits lsb through lsb+width-1 of the result hold bits width-1 through 0 of src, and every other bit equals dest.
- R3: With op = 2 (reverse), result bit 31-n equals src bit n for every n from 0 to 31; dest, lsb, width and imm have no effect.
- R4: With op = 3 (low-half load), result[15:0] equals imm and result[31:16] is zero.
- R5: With op = 4 (high-half load), result[31:16] equals imm and result[15:0] equals dest[15:0].
- R6: With op = 5 (left shift), the result is src shifted left by lsb bit places with zeros filled in, which is src times 2 to the power lsb, truncated to 32 bits.
- R7: For op 0 or 1, if width is 0 or lsb+width is greater than 32, illegal is 1 and the result equals dest; otherwise illegal is 0. For ops 2 to 5 illegal is always 0.
- R8: Op codes 6 and 7 are unused: they give illegal = 1 and a result equal to dest.
- R9: Result, valid and illegal are updated on the rising clock edge at which start is high; on an edge with start low, valid becomes 0 and result and illegal keep their values.
- R10: A synchronous active-high reset sets result to 0, valid to 0 and illegal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Strobe that samples the operands and launches an operation |
| op | input | 3 | Operation code (0 clear, 1 insert, 2 reverse, 3 low-half load, 4 high-half load, 5 left shift) |
| dest | input | 32 | Prior destination value |
| src | input | 32 | Source operand |
| lsb | input | 5 | Field start bit, or shift amount for op 5 |
| width | input | 6 | Field width, legal values 1 to 32 |
| imm | input | 16 | Half-word immediate |
| result | output | 32 | Registered result |
| valid | output | 1 | High for one cycle after each start |
| illegal | output | 1 | Registered flag for a bad field or an unused op code |

## Verification
A wrong field mask shows up as a single wrong result word on the cycle after the start strobe: bits cleared or merged outside the field, or bits left untouched inside it, visible immediately for clear and insert at the field boundaries lsb = 0, lsb = 31 and width = 32. A wrong legality decision shows on the same cycle as a flipped illegal flag, and as a result that differs from dest where pass-through was due. A broken load enable shows one cycle later, when valid stays high or result drifts with the inputs while start is low.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [2:0] {
    OP_CLR   = 3'd0,
    OP_INS   = 3'd1,
    OP_REV   = 3'd2,
    OP_MOVLO = 3'd3,
    OP_MOVHI = 3'd4,
    OP_SHL   = 3'd5
  } bfuOp_e;

  // strobes from control to datapath; at most one sel* is high
  typedef struct packed {
    logic load;
    logic selClr;
    logic selIns;
    logic selRev;
    logic selLo;
    logic selHi;
    logic selShl;
    logic selPass;
  } bfuStrobe_t;

endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int WID_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [POS_W-1:0] lsb,
  input  logic [WID_W-1:0] width,
  output bfuStrobe_t       strb,
  output logic             illegalNext
);

  localparam logic [WID_W:0] LIMIT = (WID_W+1)'(DATA_W);

  logic [WID_W:0] fieldEnd;
  logic           fieldBad;
  logic           isField;

  assign fieldEnd = {2'b00, lsb} + {1'b0, width};
  assign fieldBad = (width == '0) || (fieldEnd > LIMIT);
  assign isField  = (op == OP_CLR) || (op == OP_INS);

  always_comb begin
    strb        = '0;
    strb.load   = start;
    illegalNext = 1'b0;
    if (isField && fieldBad) begin
      strb.selPass = 1'b1;
      illegalNext  = 1'b1;
    end else begin
      case (op)
        OP_CLR:   strb.selClr = 1'b1;
        OP_INS:   strb.selIns = 1'b1;
        OP_REV:   strb.selRev = 1'b1;
        OP_MOVLO: strb.selLo  = 1'b1;
        OP_MOVHI: strb.selHi  = 1'b1;
        OP_SHL:   strb.selShl = 1'b1;
        default: begin
          strb.selPass = 1'b1;
          illegalNext  = 1'b1;
        end
      endcase
    end
  end

  // R8: exactly one datapath source is chosen for every op code
  p_one_sel_r8: assert property (@(posedge clk) disable iff (rst)
    $countones({strb.selClr, strb.selIns, strb.selRev, strb.selLo,
                strb.selHi, strb.selShl, strb.selPass}) == 1);

  // R7: a zero-width clear or insert is always flagged
  p_zero_width_r7: assert property (@(posedge clk) disable iff (rst)
    (isField && width == '0) |-> illegalNext);

  // R7: non-field ops are never flagged
  p_nonfield_ok_r7: assert property (@(posedge clk) disable iff (rst)
    (op inside {OP_REV, OP_MOVLO, OP_MOVHI, OP_SHL}) |-> !illegalNext);

endmodule

// File: rtl/bfu_dpath.sv
module bfu_dpath
  import bfu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W  = $clog2(DATA_W),
  localparam int WID_W  = POS_W + 1,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  bfuStrobe_t        strb,
  input  logic              illegalNext,
  input  logic [DATA_W-1:0] dest,
  input  logic [DATA_W-1:0] src,
  input  logic [POS_W-1:0]  lsb,
  input  logic [WID_W-1:0]  width,
  input  logic [HALF_W-1:0] imm,
  output logic [DATA_W-1:0] result,
  output logic              valid,
  output logic              illegal
);

  logic [WID_W:0]    fieldEnd;
  logic [DATA_W-1:0] fieldMask;
  logic [DATA_W-1:0] revWord;
  logic [DATA_W-1:0] shlWord;
  logic [DATA_W-1:0] nextWord;

  assign fieldEnd = {2'b00, lsb} + {1'b0, width};

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam logic [WID_W:0] IDX = (WID_W+1)'(i);
      assign fieldMask[i]        = (IDX >= {2'b00, lsb}) && (IDX < fieldEnd);
      assign revWord[DATA_W-1-i] = src[i];
    end
  endgenerate

  assign shlWord = src << lsb;

  always_comb begin
    nextWord = dest;
    unique case (1'b1)
      strb.selClr:  nextWord = dest & ~fieldMask;
      strb.selIns:  nextWord = (dest & ~fieldMask) | (shlWord & fieldMask);
      strb.selRev:  nextWord = revWord;
      strb.selLo:   nextWord = {{HALF_W{1'b0}}, imm};
      strb.selHi:   nextWord = {imm, dest[HALF_W-1:0]};
      strb.selShl:  nextWord = shlWord;
      default:      nextWord = dest;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      valid   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      valid <= strb.load;
      if (strb.load) begin
        result  <= nextWord;
        illegal <= illegalNext;
      end
    end
  end

  // R9: without a start the output word does not move
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> ($stable(result) && $stable(illegal) && !valid));

  // R7: a flagged result is the destination that was presented
  p_illegal_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (strb.load && illegalNext) |=> (illegal && result == $past(dest)));

  // R1: the cleared field reads as zero
  p_clr_field_r1: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.selClr) |=> ((result & $past(fieldMask)) == '0));

  // R4: low-half load leaves the upper half empty
  p_lo_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.selLo) |=> (result[DATA_W-1:HALF_W] == '0));

  // R5: high-half load keeps the old lower half
  p_hi_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.selHi) |=> (result[HALF_W-1:0] == $past(dest[HALF_W-1:0])));

endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W  = $clog2(DATA_W),
  localparam int WID_W  = POS_W + 1,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] dest,
  input  logic [DATA_W-1:0] src,
  input  logic [POS_W-1:0]  lsb,
  input  logic [WID_W-1:0]  width,
  input  logic [HALF_W-1:0] imm,
  output logic [DATA_W-1:0] result,
  output logic              valid,
  output logic              illegal
);

  bfuStrobe_t strb;
  logic       illegalNext;

  bfu_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .op          (op),
    .lsb         (lsb),
    .width       (width),
    .strb        (strb),
    .illegalNext (illegalNext)
  );

  bfu_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .illegalNext (illegalNext),
    .dest        (dest),
    .src         (src),
    .lsb         (lsb),
    .width       (width),
    .imm         (imm),
    .result      (result),
    .valid       (valid),
    .illegal     (illegal)
  );

endmodule

// File: tb/sim_bfu_top.sv
`timescale 1ns/1ps
module sim_bfu_top;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [31:0] dest;
    logic [31:0] src;
    logic [4:0]  lsb;
    logic [5:0]  width;
    logic [15:0] imm;
    logic [31:0] expRes;
    logic        expIll;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t TBL [0:NVEC-1] = '{
    '{4'd1,  3'd0, 32'hFFFFFFFF, 32'h00000000, 5'd5,  6'd4,  16'h0000, 32'hFFFFFE1F, 1'b0}, // R1 mid field
    '{4'd1,  3'd0, 32'hFFFFFFFF, 32'h00000000, 5'd0,  6'd32, 16'h0000, 32'h00000000, 1'b0}, // R1 full word
    '{4'd1,  3'd0, 32'hFFFFFFFF, 32'h00000000, 5'd31, 6'd1,  16'h0000, 32'h7FFFFFFF, 1'b0}, // R1 top bit
    '{4'd2,  3'd1, 32'h00000000, 32'hFFFFFFFF, 5'd5,  6'd4,  16'h0000, 32'h000001E0, 1'b0}, // R2 mid field
    '{4'd2,  3'd1, 32'hFFFF0000, 32'h0000ABCD, 5'd28, 6'd4,  16'h0000, 32'hDFFF0000, 1'b0}, // R2 top nibble
    '{4'd2,  3'd1, 32'h5555AAAA, 32'h13579BDF, 5'd0,  6'd32, 16'h0000, 32'h13579BDF, 1'b0}, // R2 full word
    '{4'd3,  3'd2, 32'hDEADBEEF, 32'h00000001, 5'd7,  6'd0,  16'hFFFF, 32'h80000000, 1'b0}, // R3 single bit
    '{4'd3,  3'd2, 32'h00000000, 32'h12345678, 5'd31, 6'd40, 16'h0000, 32'h1E6A2C48, 1'b0}, // R3 pattern
    '{4'd4,  3'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0,  6'd0,  16'h5678, 32'h00005678, 1'b0}, // R4
    '{4'd5,  3'd4, 32'hAAAA5678, 32'hFFFFFFFF, 5'd0,  6'd0,  16'h1234, 32'h12345678, 1'b0}, // R5
    '{4'd6,  3'd5, 32'hFFFFFFFF, 32'h00000003, 5'd6,  6'd0,  16'h0000, 32'h000000C0, 1'b0}, // R6 times 64
    '{4'd6,  3'd5, 32'h00000000, 32'h80000001, 5'd31, 6'd0,  16'h0000, 32'h80000000, 1'b0}, // R6 overflow drop
    '{4'd7,  3'd0, 32'h12345678, 32'h00000000, 5'd30, 6'd3,  16'h0000, 32'h12345678, 1'b1}, // R7 past top
    '{4'd7,  3'd1, 32'h87654321, 32'hFFFFFFFF, 5'd4,  6'd0,  16'h0000, 32'h87654321, 1'b1}, // R7 zero width
    '{4'd8,  3'd6, 32'hCAFEF00D, 32'hFFFFFFFF, 5'd0,  6'd1,  16'h0000, 32'hCAFEF00D, 1'b1}, // R8 code 6
    '{4'd8,  3'd7, 32'h0BADF00D, 32'h00000000, 5'd0,  6'd1,  16'hFFFF, 32'h0BADF00D, 1'b1}  // R8 code 7
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  op;
  logic [31:0] dest, src;
  logic [4:0]  lsb;
  logic [5:0]  width;
  logic [15:0] imm;
  logic [31:0] result;
  logic        valid, illegal;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  bfu_top u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .dest(dest), .src(src),
    .lsb(lsb), .width(width), .imm(imm),
    .result(result), .valid(valid), .illegal(illegal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    start = 1'b1; op = v.op; dest = v.dest; src = v.src;
    lsb = v.lsb; width = v.width; imm = v.imm;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst = 1'b1; start = 1'b0; op = '0; dest = '0; src = '0;
    lsb = '0; width = '0; imm = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 result after reset", result, 32'h0);
    check("R10 valid after reset", {31'b0, valid}, 32'h0);
    check("R10 illegal after reset", {31'b0, illegal}, 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      launch(TBL[k]);
      check($sformatf("R%0d vec %0d result", TBL[k].req, k), result, TBL[k].expRes);
      check($sformatf("R%0d vec %0d illegal", TBL[k].req, k), {31'b0, illegal}, {31'b0, TBL[k].expIll});
      check($sformatf("R9 vec %0d valid", k), {31'b0, valid}, 32'h1);
      held = result;
      // R9: start low, inputs disturbed, outputs must hold
      dest = ~dest; src = ~src; imm = ~imm;
      @(negedge clk);
      check($sformatf("R9 vec %0d valid drop", k), {31'b0, valid}, 32'h0);
      check($sformatf("R9 vec %0d result hold", k), result, held);
      check($sformatf("R9 vec %0d illegal hold", k), {31'b0, illegal}, {31'b0, TBL[k].expIll});
    end

    // R9: back-to-back starts update on each edge
    @(negedge clk);
    start = 1'b1; op = 3'd3; imm = 16'h0001;
    @(negedge clk);
    check("R9 b2b first", result, 32'h00000001);
    op = 3'd4; dest = 32'h0000BEEF; imm = 16'hFACE;
    @(negedge clk);
    start = 1'b0;
    check("R9 b2b second", result, 32'hFACEBEEF);
    check("R9 b2b valid", {31'b0, valid}, 32'h1);

    // R1: field exactly reaching bit 31 is legal
    launch('{4'd1, 3'd0, 32'hFFFFFFFF, 32'h0, 5'd16, 6'd16, 16'h0, 32'h0000FFFF, 1'b0});
    check("R1 upper half clear", result, 32'h0000FFFF);
    check("R7 edge legal", {31'b0, illegal}, 32'h0);

    // R7: width above 32 at lsb 0 is flagged
    launch('{4'd7, 3'd0, 32'h600DCAFE, 32'h0, 5'd0, 6'd33, 16'h0, 32'h600DCAFE, 1'b1});
    check("R7 width 33 result", result, 32'h600DCAFE);
    check("R7 width 33 flag", {31'b0, illegal}, 32'h1);

    // R10: reset after an illegal result clears everything
    @(negedge clk);
    start = 1'b1; op = 3'd5; src = 32'h1; lsb = 5'd4;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; start = 1'b0;
    check("R10 mid result", result, 32'h0);
    check("R10 mid valid", {31'b0, valid}, 32'h0);
    check("R10 mid illegal", {31'b0, illegal}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule